// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers event sources from a power-management companion into a 16-bit interrupt status word. It keeps a 16-bit mask word beside it, and it drives one level-sensitive interrupt line. That line is high whenever any status bit is set and the matching mask bit is clear. Three sources arrive as one-cycle strobes: a real-time-clock periodic tick, a real-time-clock alarm match and a real-time-clock update error. The fourth source is the raw level of a push button, and the block detects its rising edge internally.

Software reaches the block through a byte-wide register port. The status word, the mask word and the acknowledge strobes each have their own address for the low byte and for the high byte. A status bit is cleared by writing one to the matching bit at an acknowledge address. The port is a plain control port with no back-pressure. A write is accepted in every cycle in which `reg_wr_i` is high. Read data is a combinational function of `reg_addr_i` and is valid in that same cycle.

Top module: `pmic_irq_ctrl`

## Requirements
- R1: After reset the status word is 0x0000, the mask word is 0x0FFF and `irq_o` is low.
- R2: `irq_o` is high exactly when some bit is set both in the status word and in the inverted mask word. It follows each mask write, acknowledge write and event on the cycle after the clock edge that applied it.
- R3: A one-cycle strobe on `evt_tick_i`, `evt_alarm_i` or `evt_err_i` sets status bit 8, 9 or 10 respectively at the next clock edge. Once set, the bit stays set until it is acknowledged.
- R4: Status bit 11 is set only in the cycle after `btn_level_i` changes from low to high. A level that stays high does not set the bit again after it has been acknowledged. The button is taken as low during reset.
- R5: A write of value V to address 4 clears every status bit in 7:0 where V has a one. Status bits 15:8 are not changed.
- R6: A write of value V to address 5 clears every status bit in 15:8 where bit (n-8) of V is one. Status bits 7:0 are not changed.
- R7: Reads from addresses 4 and 5 return 0x00.
- R8: A write to address 2 loads mask bits 7:0 and a write to address 3 loads mask bits 15:8. The other byte of the mask keeps its value. Reads from address 2 and address 3 return the corresponding mask byte.
- R9: A read from address 0 returns status bits 7:0 and a read from address 1 returns status bits 15:8. Any unlisted address (6 or 7) reads 0x00.
- R10: When an event and an acknowledge hit the same status bit in one cycle, the event wins and the bit stays set.
- R11: Status bits 0 to 7 and 12 to 15 have no source and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 3 | Register address: 0/1 status lo/hi, 2/3 mask lo/hi, 4/5 acknowledge lo/hi |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| evt_tick_i | input | 1 | Periodic-tick strobe (status bit 8) |
| evt_alarm_i | input | 1 | Alarm strobe (status bit 9) |
| evt_err_i | input | 1 | Update-error strobe (status bit 10) |
| btn_level_i | input | 1 | Raw push-button level (status bit 11 on rising edge) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the inputs are synchronous to `clk_i` and that `rst_ni` is held low for at least one edge before any checking starts. They also assume that an event strobe is a single-cycle pulse. The edge-detector property does not depend on that, but the per-bit set and hold properties read each high strobe cycle as a fresh event. The stimulus drives every input on the falling clock edge. It raises each event strobe for exactly one cycle and then lowers it. The button level changes only at the start of a step, and the button is kept low across every reset, so no unexpected press is recorded when reset is released.

// File: rtl/pmic_irq_pkg.sv
package pmic_irq_pkg;
  localparam int STAT_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT_LO = 3'd0,
    A_STAT_HI = 3'd1,
    A_MASK_LO = 3'd2,
    A_MASK_HI = 3'd3,
    A_ACK_LO  = 3'd4,
    A_ACK_HI  = 3'd5
  } reg_addr_e;

  localparam int BIT_TICK  = 8;
  localparam int BIT_ALARM = 9;
  localparam int BIT_ERR   = 10;
  localparam int BIT_BTN   = 11;

  localparam logic [STAT_W-1:0] MASK_RESET = 16'h0FFF;
endpackage

// File: rtl/pmic_irq_edge.sv
module pmic_irq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  // A level held high yields a single-cycle pulse only (R4)
  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pmic_irq_bit.sv
module pmic_irq_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic bit_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)    bit_o <= 1'b0;
    else if (set_i) bit_o <= 1'b1;   // event beats acknowledge
    else if (ack_i) bit_o <= 1'b0;
  end

  // R3 and R10: an event always leaves the bit set
  assert_event_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> bit_o);
  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !bit_o);
  assert_idle_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !set_i) |=> $stable(bit_o));
endmodule

// File: rtl/pmic_irq_regif.sv
module pmic_irq_regif
  import pmic_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  input  logic [STAT_W-1:0]    status_i,
  output logic [STAT_W-1:0]    mask_o,
  output logic [STAT_W-1:0]    ack_o,
  output logic [BYTE_W-1:0]    rdata_o
);
  localparam int NBYTES = STAT_W / BYTE_W;

  logic [NBYTES-1:0] mask_we;
  logic [NBYTES-1:0] ack_we;

  assign mask_we[0] = wr_i && (addr_i == A_MASK_LO);
  assign mask_we[1] = wr_i && (addr_i == A_MASK_HI);
  assign ack_we[0]  = wr_i && (addr_i == A_ACK_LO);
  assign ack_we[1]  = wr_i && (addr_i == A_ACK_HI);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (!rst_ni)         mask_o[b*BYTE_W +: BYTE_W] <= MASK_RESET[b*BYTE_W +: BYTE_W];
      else if (mask_we[b]) mask_o[b*BYTE_W +: BYTE_W] <= wdata_i;
    end
    assign ack_o[b*BYTE_W +: BYTE_W] = ack_we[b] ? wdata_i : '0;
  end

  always_comb begin
    unique case (addr_i)
      A_STAT_LO: rdata_o = status_i[BYTE_W-1:0];
      A_STAT_HI: rdata_o = status_i[STAT_W-1:BYTE_W];
      A_MASK_LO: rdata_o = mask_o[BYTE_W-1:0];
      A_MASK_HI: rdata_o = mask_o[STAT_W-1:BYTE_W];
      default:   rdata_o = '0;
    endcase
  end

  assert_mask_lo_keeps_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we[0] |=> $stable(mask_o[STAT_W-1:BYTE_W]));
  assert_mask_hi_keeps_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we[1] |=> $stable(mask_o[BYTE_W-1:0]));
  assert_ack_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_ACK_LO || addr_i == A_ACK_HI) |-> rdata_o == '0);
endmodule

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl
  import pmic_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              evt_tick_i,
  input  logic              evt_alarm_i,
  input  logic              evt_err_i,
  input  logic              btn_level_i,
  output logic              irq_o
);
  logic              btn_rise;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] ack_vec;
  logic [STAT_W-1:0] mask;
  logic [STAT_W-1:0] status;

  pmic_irq_edge u_btn_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (btn_level_i),
    .rise_o  (btn_rise)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_TICK]  = evt_tick_i;
    set_vec[BIT_ALARM] = evt_alarm_i;
    set_vec[BIT_ERR]   = evt_err_i;
    set_vec[BIT_BTN]   = btn_rise;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    pmic_irq_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[i]),
      .ack_i  (ack_vec[i]),
      .bit_o  (status[i])
    );
  end

  pmic_irq_regif u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status),
    .mask_o   (mask),
    .ack_o    (ack_vec),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o = |(status & ~mask);

  assert_irq_needs_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status != '0);
  assert_low_byte_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_STAT_LO) |-> reg_rdata_o == '0);
  assert_event_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_alarm_i && ack_vec[BIT_ALARM]) |=> status[BIT_ALARM]);
endmodule

// File: tb/pmic_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pmic_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick = 1'b0, alarm = 1'b0, err = 1'b0, btn = 1'b0;
  logic       irq;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pmic_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_tick_i(tick),
    .evt_alarm_i(alarm), .evt_err_i(err), .btn_level_i(btn), .irq_o(irq)
  );

  // Vector: {req[31:28], wr[27], addr[26:24], wdata[23:16], ev{err,alarm,tick}[15:13],
  //          btn[12], raddr[11:9], exp_rdata[8:1], exp_irq[0]}
  localparam int NV = 21;
  localparam logic [31:0] VEC [NV] = '{
    {4'd3,  1'b0, 3'd0, 8'h00, 3'b001, 1'b0, 3'd1, 8'h01, 1'b0}, // R3 tick sets bit 8, masked
    {4'd2,  1'b1, 3'd3, 8'h00, 3'b000, 1'b0, 3'd1, 8'h01, 1'b1}, // R2 unmask high byte
    {4'd8,  1'b0, 3'd0, 8'h00, 3'b000, 1'b0, 3'd2, 8'hFF, 1'b1}, // R8 mask lo readback
    {4'd6,  1'b1, 3'd5, 8'h01, 3'b000, 1'b0, 3'd1, 8'h00, 1'b0}, // R6 ack bit 8
    {4'd3,  1'b0, 3'd0, 8'h00, 3'b010, 1'b0, 3'd1, 8'h02, 1'b1}, // R3 alarm
    {4'd3,  1'b0, 3'd0, 8'h00, 3'b100, 1'b0, 3'd1, 8'h06, 1'b1}, // R3 error
    {4'd10, 1'b1, 3'd5, 8'h02, 3'b010, 1'b0, 3'd1, 8'h06, 1'b1}, // R10 event beats ack
    {4'd6,  1'b1, 3'd5, 8'h06, 3'b000, 1'b0, 3'd1, 8'h00, 1'b0}, // R6 ack two bits
    {4'd4,  1'b0, 3'd0, 8'h00, 3'b000, 1'b1, 3'd1, 8'h08, 1'b1}, // R4 button rise
    {4'd4,  1'b1, 3'd5, 8'h08, 3'b000, 1'b1, 3'd1, 8'h00, 1'b0}, // R4 ack while held
    {4'd4,  1'b0, 3'd0, 8'h00, 3'b000, 1'b1, 3'd1, 8'h00, 1'b0}, // R4 held: no re-set
    {4'd4,  1'b0, 3'd0, 8'h00, 3'b000, 1'b0, 3'd1, 8'h00, 1'b0}, // R4 release
    {4'd4,  1'b0, 3'd0, 8'h00, 3'b000, 1'b1, 3'd1, 8'h08, 1'b1}, // R4 second press
    {4'd8,  1'b1, 3'd3, 8'h08, 3'b000, 1'b1, 3'd3, 8'h08, 1'b0}, // R8 mask bit 11
    {4'd5,  1'b1, 3'd4, 8'hFF, 3'b000, 1'b1, 3'd1, 8'h08, 1'b0}, // R5 lo ack spares hi
    {4'd7,  1'b0, 3'd0, 8'h00, 3'b000, 1'b1, 3'd5, 8'h00, 1'b0}, // R7 ack hi reads 0
    {4'd8,  1'b1, 3'd2, 8'h00, 3'b000, 1'b1, 3'd3, 8'h08, 1'b0}, // R8 lo write keeps hi
    {4'd2,  1'b0, 3'd0, 8'h00, 3'b001, 1'b1, 3'd1, 8'h09, 1'b1}, // R2 tick unmasked
    {4'd11, 1'b0, 3'd0, 8'h00, 3'b000, 1'b1, 3'd0, 8'h00, 1'b1}, // R11 low byte zero
    {4'd9,  1'b1, 3'd5, 8'hFF, 3'b000, 1'b1, 3'd6, 8'h00, 1'b0}, // R9 unlisted addr
    {4'd9,  1'b0, 3'd0, 8'h00, 3'b000, 1'b0, 3'd1, 8'h00, 1'b0}  // R9 status hi clear
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp,
                       input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] v);
    @(negedge clk);
    wr    = v[27];
    addr  = v[26:24];
    wdata = v[23:16];
    err   = v[15];
    alarm = v[14];
    tick  = v[13];
    btn   = v[12];
    @(posedge clk);
    #1;
    wr = 1'b0; tick = 1'b0; alarm = 1'b0; err = 1'b0;
    addr = v[11:9];
    #0.5;
    check(int'(v[31:28]), rdata, v[8:1], "rdata");
    check(int'(v[31:28]), {7'd0, irq}, {7'd0, v[0]}, "irq");
  endtask

  task automatic read_at(input int req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #0.5;
    check(req, rdata, exp, "read");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        read_at(1, 3'd2, 8'hFF);
        read_at(1, 3'd3, 8'h0F);
        read_at(1, 3'd1, 8'h00);
        check(1, {7'd0, irq}, 8'h00, "irq after reset");
        for (int i = 0; i < NV; i++) step(VEC[i]);
        // Directed: reset in the middle restores defaults (R1)
        step({4'd3, 1'b1, 3'd3, 8'h00, 3'b011, 1'b0, 3'd1, 8'h03, 1'b1}); // R3
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        read_at(1, 3'd1, 8'h00);
        read_at(1, 3'd3, 8'h0F);
        check(1, {7'd0, irq}, 8'h00, "irq after mid reset");
        // R7 ack lo reads zero
        read_at(7, 3'd4, 8'h00);
        // R11 unconnected high nibble: unmask all, pulse everything, bits 15:12 stay 0
        step({4'd11, 1'b1, 3'd3, 8'h00, 3'b111, 1'b0, 3'd1, 8'h07, 1'b1});
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_errors++;
          $display("FAIL R1 watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule